// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the control logic of a parallel block-erase NOR flash device. A fast system clock samples the asynchronous active-low strobes of the device (chip select, output enable, write strobe, reset/power-down and byte select). The block also samples the address and data pins. Bus writes are decoded as commands that pick one of three read views: array data, identifier codes or the status byte. Other commands start single-word program or block-erase jobs. The memory array and its program/erase algorithm are not part of the block. They sit behind a simple port: a level request, a one-cycle done pulse, a one-cycle abort pulse, and a synchronous read address and data pair.

The block drives the data-bus output enables (one for the low lane and one for the high lane) and the ready/busy pin. It resolves each target address to an erase-block index through a fixed, non-uniform block map. It also keeps one flag per block that marks the block as holding invalid data after an aborted job. Pulling the reset/power-down pin low puts the block into power-down. In power-down it ignores the bus, cancels any running job and, on exit, comes back in array mode with a clean status byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Command bytes are taken from data bits 7:0. FFh selects array reads, 90h selects identifier reads and 70h selects status reads. In identifier mode, word address bit 0 = 0 returns MFR_ID and bit 0 = 1 returns DEV_ID. In status mode the word reads {8'h00, status}.
- R2: After reset, and after leaving power-down, reads return array data. The status byte is 80h, ready/busy is high and both output enables are low.
- R3: A bus write is accepted only while ce_n=0, oe_n=1, we_n=0 and rp_n=1. Its address and data are the values held when the first of we_n or ce_n rises. Pin changes after that rise have no effect on the write.
- R4: Writing 40h and then any bus write starts a program job. The job carries the address and data of that second write (arr_op=0), and the block switches to status reads. When arr_done arrives, the program is complete.
- R5: Both output enables are low whenever oe_n, ce_n or rp_n is inactive. During a word-mode read both are high.
- R6: While rp_n is low, bus writes are ignored. The block is in array mode and the status byte is 80h.
- R7: If rp_n goes low during a job, the job ends with a single arr_abort pulse, bad_blk bit for the job's block is set and ready/busy returns high.
- R8: With ce_n high the running job continues, and ready/busy stays low until arr_done.
- R9: With byte_n low, only the low lane is driven. Pin dq_in[15] acts as the byte address: 0 selects word bits 7:0 and 1 selects word bits 15:8, both returned on dq_out[7:0]. A byte program writes the selected byte and fills the other byte with FFh.
- R10: With B = 2^BOOT_LOG2 words, the block map is: block 0 = [0,B), block 1 = [B,1.5B), block 2 = [1.5B,2B), block 3 = [2B,4B), and each further block covers 4B words.
- R11: Writing 20h followed by D0h starts an erase of the second write's block (arr_op=1). A successful erase clears that block's bad_blk bit. Any byte other than D0h sets status bits 5 and 4, starts no job and selects status reads.
- R12: Status bit 7 is 1 when the block is ready and 0 while a job runs, and ry_by follows it. Status bits 5 and 4 stay set until a 50h command.
- R13: While a job runs, only 70h is acted on. Every other write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| rp_n | input | 1 | Reset/power-down, active low, asynchronous |
| byte_n | input | 1 | Low selects byte-wide bus |
| addr | input | AW | Word address pins |
| dq_in | input | 16 | Data pins in; bit 15 is byte address in byte mode |
| dq_out | output | 16 | Data pins out |
| dq_oe | output | 2 | Drive enables: bit 0 for D7..D0, bit 1 for D15..D8 |
| ry_by | output | 1 | High when ready, low while a job runs |
| arr_rd_addr | output | AW | Array read address |
| arr_rd_data | input | 16 | Array read data, one cycle after the address |
| arr_req | output | 1 | Job request, held until done or abort |
| arr_op | output | 1 | 0 = program, 1 = erase |
| arr_addr | output | AW | Job target address |
| arr_blk | output | BW | Job target block index |
| arr_wdata | output | 16 | Program data |
| arr_done | input | 1 | One-cycle pulse when the job finishes |
| arr_abort | output | 1 | One-cycle pulse when a job is cancelled |
| bad_blk | output | NBLK | Per-block invalid-data flags |

## Verification
The bench builds the block with AW=12 and BOOT_LOG2=8, so the map has seven blocks of 256, 128, 128, 512 and three times 1024 words. A full model of the array fits in the bench at this size. Every block boundary is then within a short erase sweep, including the last word of the address space. The bench holds the model's done pulse back to keep a job running. This lets it test deselection, ignored commands and power-down aborts in the middle of a job.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_t;

  typedef enum logic [1:0] {
    SQ_CMD   = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_ERASE = 2'd2
  } seq_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_PROGRAM  = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

endpackage

// File: rtl/fcc_pin_sync.sv
module fcc_pin_sync #(
  parameter int AW     = 19,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          byte_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic          rp_s,
  output logic          byte_n_s,
  output logic          rd_en,
  output logic [AW-1:0] addr_s,
  output logic          am1_s,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          wr_am1,
  output logic          wr_byte_n
);

  localparam int PW = 5 + AW + 16;
  localparam logic [PW-1:0] IDLE_VAL = {5'b11111, {(AW + 16){1'b0}}};

  logic [PW-1:0] pins;
  logic [PW-1:0] stage [STAGES];
  logic [PW-1:0] tail;

  assign pins = {ce_n, oe_n, we_n, rp_n, byte_n, addr, dq_in};

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= IDLE_VAL;
          else     stage[g] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= IDLE_VAL;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign tail = stage[STAGES-1];

  logic ce_s, oe_s, we_s;
  logic [15:0] dq_s;

  assign ce_s     = tail[PW-1];
  assign oe_s     = tail[PW-2];
  assign we_s     = tail[PW-3];
  assign rp_s     = tail[PW-4];
  assign byte_n_s = tail[PW-5];
  assign addr_s   = tail[AW+15:16];
  assign dq_s     = tail[15:0];
  assign am1_s    = dq_s[15];

  logic wr_act, wr_act_q;

  assign wr_act = !ce_s && !we_s && oe_s && rp_s;
  assign rd_en  = !ce_s && !oe_s && we_s && rp_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q  <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_am1    <= 1'b0;
      wr_byte_n <= 1'b1;
    end else begin
      wr_act_q <= wr_act;
      wr_stb   <= wr_act_q && !wr_act && rp_s;
      if (wr_act) begin
        wr_addr   <= addr_s;
        wr_data   <= dq_s;
        wr_am1    <= dq_s[15];
        wr_byte_n <= byte_n_s;
      end
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);  // R3

  AST_WR_NEEDS_RP: assert property (@(posedge clk) disable iff (rst)
    !rp_s |=> !wr_stb);  // R6

endmodule

// File: rtl/fcc_blk_map.sv
module fcc_blk_map #(
  parameter int AW        = 19,
  parameter int BOOT_LOG2 = 13,
  parameter int BW        = 5
) (
  input  logic [AW-1:0] addr,
  output logic [BW-1:0] blk
);

  localparam int BOOT_W   = 1 << BOOT_LOG2;
  localparam int BIG_LOG2 = BOOT_LOG2 + 2;
  localparam logic [AW-1:0] LIM_BOOT = AW'(BOOT_W);
  localparam logic [AW-1:0] LIM_P1   = AW'(BOOT_W + BOOT_W / 2);
  localparam logic [AW-1:0] LIM_P2   = AW'(2 * BOOT_W);
  localparam logic [AW-1:0] LIM_M0   = AW'(4 * BOOT_W);

  logic [AW-BIG_LOG2-1:0] big_idx;

  assign big_idx = addr[AW-1:BIG_LOG2];

  always_comb begin
    if (addr < LIM_BOOT)    blk = '0;
    else if (addr < LIM_P1) blk = BW'(1);
    else if (addr < LIM_P2) blk = BW'(2);
    else if (addr < LIM_M0) blk = BW'(3);
    else                    blk = BW'(3) + BW'(big_idx);
  end

endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
  import fcc_pkg::*;
#(
  parameter int AW   = 19,
  parameter int NBLK = 19,
  parameter int BW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rp_s,
  input  logic            wr_stb,
  input  logic [AW-1:0]   wr_addr,
  input  logic [15:0]     wr_data,
  input  logic            wr_am1,
  input  logic            wr_byte_n,
  input  logic [BW-1:0]   wr_blk,
  input  logic            arr_done,
  output rmode_t          rmode,
  output logic [7:0]      status,
  output logic            arr_req,
  output logic            arr_op,
  output logic [AW-1:0]   arr_addr,
  output logic [BW-1:0]   arr_blk,
  output logic [15:0]     arr_wdata,
  output logic            arr_abort,
  output logic [NBLK-1:0] bad_blk
);

  seq_t       seq;
  logic       busy;
  logic       err_erase;
  logic       err_seq;
  logic [7:0] cmd;
  logic [15:0] prog_word;
  logic       clr_req;

  assign cmd = wr_data[7:0];

  always_comb begin
    if (wr_byte_n)   prog_word = wr_data;
    else if (wr_am1) prog_word = {wr_data[7:0], 8'hFF};
    else             prog_word = {8'hFF, wr_data[7:0]};
  end

  assign clr_req = wr_stb && !busy && (seq == SQ_CMD) && (cmd == CMD_CLR_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rmode     <= RM_ARRAY;
      seq       <= SQ_CMD;
      busy      <= 1'b0;
      err_erase <= 1'b0;
      err_seq   <= 1'b0;
      arr_op    <= 1'b0;
      arr_addr  <= '0;
      arr_blk   <= '0;
      arr_wdata <= '0;
      arr_abort <= 1'b0;
      bad_blk   <= '0;
    end else begin
      arr_abort <= 1'b0;
      if (!rp_s) begin
        rmode     <= RM_ARRAY;
        seq       <= SQ_CMD;
        err_erase <= 1'b0;
        err_seq   <= 1'b0;
        if (busy) begin
          busy             <= 1'b0;
          arr_abort        <= 1'b1;
          bad_blk[arr_blk] <= 1'b1;
        end
      end else if (busy) begin
        if (arr_done) begin
          busy <= 1'b0;
          if (arr_op) bad_blk[arr_blk] <= 1'b0;
        end
        if (wr_stb && cmd == CMD_RD_STAT) rmode <= RM_STATUS;
      end else if (wr_stb) begin
        unique case (seq)
          SQ_PROG: begin
            busy      <= 1'b1;
            arr_op    <= 1'b0;
            arr_addr  <= wr_addr;
            arr_blk   <= wr_blk;
            arr_wdata <= prog_word;
            seq       <= SQ_CMD;
            rmode     <= RM_STATUS;
          end
          SQ_ERASE: begin
            if (cmd == CMD_CONFIRM) begin
              busy     <= 1'b1;
              arr_op   <= 1'b1;
              arr_addr <= wr_addr;
              arr_blk  <= wr_blk;
            end else begin
              err_erase <= 1'b1;
              err_seq   <= 1'b1;
            end
            seq   <= SQ_CMD;
            rmode <= RM_STATUS;
          end
          default: begin
            unique case (cmd)
              CMD_RD_ARRAY: rmode <= RM_ARRAY;
              CMD_RD_IDENT: rmode <= RM_IDENT;
              CMD_RD_STAT:  rmode <= RM_STATUS;
              CMD_CLR_STAT: begin
                err_erase <= 1'b0;
                err_seq   <= 1'b0;
              end
              CMD_PROGRAM:  seq <= SQ_PROG;
              CMD_ERASE:    seq <= SQ_ERASE;
              default:      ;
            endcase
          end
        endcase
      end
    end
  end

  assign arr_req = busy;
  assign status  = {!busy, 1'b0, err_erase, err_seq, 4'b0000};

  AST_PD_STATE: assert property (@(posedge clk) disable iff (rst)
    !rp_s |=> (rmode == RM_ARRAY) && (status == 8'h80));  // R6

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    arr_abort |-> $past(!rp_s) && !arr_req);  // R7

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    arr_abort |=> !arr_abort);  // R7

  AST_JOB_HOLDS: assert property (@(posedge clk) disable iff (rst)
    arr_req && rp_s && !arr_done |=> arr_req && $stable(arr_blk) && $stable(arr_op));  // R8

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    arr_req && arr_done |=> status[7]);  // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    status[5] && rp_s && !clr_req |=> status[5]);  // R12

  AST_BLK_RANGE: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> 32'(arr_blk) < NBLK);  // R10

endmodule

// File: rtl/fcc_rd_path.sv
module fcc_rd_path
  import fcc_pkg::*;
#(
  parameter int          AW     = 19,
  parameter logic [15:0] MFR_ID = 16'h00A7,
  parameter logic [15:0] DEV_ID = 16'h5D31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          byte_n_s,
  input  logic          am1_s,
  input  logic [AW-1:0] addr_s,
  input  rmode_t        rmode,
  input  logic [7:0]    status,
  input  logic [15:0]   arr_rd_data,
  output logic [AW-1:0] arr_rd_addr,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe
);

  logic [15:0] word;

  always_comb begin
    unique case (rmode)
      RM_IDENT:  word = arr_rd_addr[0] ? DEV_ID : MFR_ID;
      RM_STATUS: word = {8'h00, status};
      default:   word = arr_rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_rd_addr <= '0;
      dq_out      <= '0;
      dq_oe       <= 2'b00;
    end else begin
      arr_rd_addr <= addr_s;
      dq_oe       <= rd_en ? {byte_n_s, 1'b1} : 2'b00;
      if (byte_n_s) dq_out <= word;
      else          dq_out <= {8'h00, am1_s ? word[15:8] : word[7:0]};
    end
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> dq_oe == 2'b00);  // R5

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
    !byte_n_s |=> !dq_oe[1] && dq_out[15:8] == 8'h00);  // R9

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int          AW          = 19,
  parameter int          BOOT_LOG2   = 13,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MFR_ID      = 16'h00A7,
  parameter logic [15:0] DEV_ID      = 16'h5D31,
  parameter int          NBLK        = 3 + (1 << (AW - BOOT_LOG2 - 2)),
  parameter int          BW          = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic            rp_n,
  input  logic            byte_n,
  input  logic [AW-1:0]   addr,
  input  logic [15:0]     dq_in,
  output logic [15:0]     dq_out,
  output logic [1:0]      dq_oe,
  output logic            ry_by,
  output logic [AW-1:0]   arr_rd_addr,
  input  logic [15:0]     arr_rd_data,
  output logic            arr_req,
  output logic            arr_op,
  output logic [AW-1:0]   arr_addr,
  output logic [BW-1:0]   arr_blk,
  output logic [15:0]     arr_wdata,
  input  logic            arr_done,
  output logic            arr_abort,
  output logic [NBLK-1:0] bad_blk
);

  logic          rp_s, byte_n_s, rd_en, am1_s;
  logic [AW-1:0] addr_s;
  logic          wr_stb, wr_am1, wr_byte_n;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic [BW-1:0] wr_blk;
  rmode_t        rmode;
  logic [7:0]    status;

  fcc_pin_sync #(.AW(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n), .byte_n(byte_n),
    .addr(addr), .dq_in(dq_in),
    .rp_s(rp_s), .byte_n_s(byte_n_s), .rd_en(rd_en),
    .addr_s(addr_s), .am1_s(am1_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_am1(wr_am1), .wr_byte_n(wr_byte_n)
  );

  fcc_blk_map #(.AW(AW), .BOOT_LOG2(BOOT_LOG2), .BW(BW)) u_map (
    .addr(wr_addr), .blk(wr_blk)
  );

  fcc_cmd_fsm #(.AW(AW), .NBLK(NBLK), .BW(BW)) u_fsm (
    .clk(clk), .rst(rst), .rp_s(rp_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_am1(wr_am1), .wr_byte_n(wr_byte_n), .wr_blk(wr_blk),
    .arr_done(arr_done),
    .rmode(rmode), .status(status),
    .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_blk(arr_blk), .arr_wdata(arr_wdata), .arr_abort(arr_abort),
    .bad_blk(bad_blk)
  );

  fcc_rd_path #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .byte_n_s(byte_n_s),
    .am1_s(am1_s), .addr_s(addr_s), .rmode(rmode), .status(status),
    .arr_rd_data(arr_rd_data), .arr_rd_addr(arr_rd_addr),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign ry_by = status[7];

  AST_RB_TRACKS_JOB: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> !ry_by);  // R12

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int AW        = 12;
  localparam int BOOT_LOG2 = 8;
  localparam int NBLK      = 3 + (1 << (AW - BOOT_LOG2 - 2));
  localparam int BW        = $clog2(NBLK);
  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h5D31;
  localparam int K_DQ = 0, K_OE = 1, K_RB = 2, K_BAD = 3, K_WDATA = 4,
                 K_BLK = 5, K_OP = 6, K_ABORTS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, byte_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic ry_by, arr_req, arr_op, arr_abort;
  logic [AW-1:0] arr_rd_addr, arr_addr;
  logic [15:0] arr_rd_data, arr_wdata;
  logic [BW-1:0] arr_blk;
  logic [NBLK-1:0] bad_blk;
  logic arr_done = 1'b0;

  flash_cmd_ctrl #(.AW(AW), .BOOT_LOG2(BOOT_LOG2), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .ry_by(ry_by), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr), .arr_blk(arr_blk),
    .arr_wdata(arr_wdata), .arr_done(arr_done), .arr_abort(arr_abort),
    .bad_blk(bad_blk)
  );

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  // Array model: synchronous read, program applied on done
  logic [15:0] mem [1 << AW];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= init_val(i);
      arr_rd_data <= '0;
    end else begin
      arr_rd_data <= mem[arr_rd_addr];
      if (arr_done && arr_req && !arr_op) mem[arr_addr] <= arr_wdata;
    end
  end

  // Job responder
  bit stall = 1'b0;
  int job_cnt = 0;
  always @(posedge clk) begin
    if (!arr_req) begin
      job_cnt  <= 0;
      arr_done <= 1'b0;
    end else if (arr_done) begin
      arr_done <= 1'b0;
    end else if (job_cnt >= 20 && !stall) begin
      arr_done <= 1'b1;
    end else begin
      job_cnt <= job_cnt + 1;
    end
  end

  // Capture of job fields at request start, abort counting
  logic req_q = 1'b0;
  logic [15:0] cap_wdata = '0;
  logic [BW-1:0] cap_blk = '0;
  logic cap_op = 1'b0;
  int abort_cnt = 0;
  always @(posedge clk) begin
    req_q <= arr_req;
    if (arr_req && !req_q) begin
      cap_wdata <= arr_wdata;
      cap_blk   <= arr_blk;
      cap_op    <= arr_op;
    end
    if (!rst && arr_abort) abort_cnt <= abort_cnt + 1;
  end

  // Scoreboard
  typedef struct {
    int          kind;
    logic [15:0] val;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  smp_ev;
  int    checks = 0;
  int    failures = 0;

  task automatic expect_item(input int kind, input logic [15:0] val, input string tag);
    item_t it;
    it.kind = kind;
    it.val  = val;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] obs;
        it = exp_q.pop_front();
        case (it.kind)
          K_DQ:     obs = dq_out;
          K_OE:     obs = 16'(dq_oe);
          K_RB:     obs = 16'(ry_by);
          K_BAD:    obs = 16'(bad_blk);
          K_WDATA:  obs = cap_wdata;
          K_BLK:    obs = 16'(cap_blk);
          K_OP:     obs = 16'(cap_op);
          default:  obs = 16'(abort_cnt);
        endcase
        checks++;
        if (obs !== it.val) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", it.tag, obs, it.val);
        end
      end
    end
  end

  task automatic sample_now();
    -> smp_ev;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d, input bit ce_first);
    @(negedge clk);
    addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    addr = ~a; dq_in = ~d;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic am1, input logic [15:0] exp,
                          input logic [1:0] exp_oe, input string tag);
    @(negedge clk);
    addr = a; dq_in = {am1, 15'h0}; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (8) @(negedge clk);
    expect_item(K_DQ, exp, tag);
    expect_item(K_OE, 16'(exp_oe), tag);
    sample_now();
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ready();
    repeat (3) @(negedge clk);
    while (ry_by !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2: reset state
    expect_item(K_OE, 16'h0000, "R2 reset oe");
    expect_item(K_RB, 16'h0001, "R2 reset ready");
    sample_now();
    read_chk(12'd5, 1'b0, init_val(5), 2'b11, "R2 array after reset");

    // R1: identifier and status views
    bus_write(12'h000, 16'h0090, 1'b0);
    read_chk(12'd0, 1'b0, MFR, 2'b11, "R1 ident mfr");
    read_chk(12'd1, 1'b0, DEV, 2'b11, "R1 ident dev");
    bus_write(12'h000, 16'h0070, 1'b0);
    read_chk(12'd7, 1'b0, 16'h0080, 2'b11, "R1 status view");

    // R5: ce low, oe high -> not driven
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    repeat (8) @(negedge clk);
    expect_item(K_OE, 16'h0000, "R5 oe high");
    sample_now();
    ce_n = 1'b1;

    // R3/R4: program, data latched on the chip-select rise
    stall = 1'b1;
    bus_write(12'h000, 16'h0040, 1'b0);
    bus_write(12'd300, 16'h1234, 1'b1);
    expect_item(K_RB, 16'h0000, "R12 busy during program");
    expect_item(K_WDATA, 16'h1234, "R3 data at first rise");
    expect_item(K_BLK, 16'd1, "R4 program block");
    expect_item(K_OP, 16'd0, "R4 program op");
    sample_now();
    stall = 1'b0;
    wait_ready();
    bus_write(12'h000, 16'h00FF, 1'b0);
    read_chk(12'd300, 1'b0, 16'h1234, 2'b11, "R4 programmed word");

    // R13/R8: ignored commands and deselect during a job
    stall = 1'b1;
    bus_write(12'h000, 16'h0040, 1'b0);
    bus_write(12'd301, 16'h5555, 1'b0);
    bus_write(12'h000, 16'h00FF, 1'b0);
    read_chk(12'd301, 1'b0, 16'h0000, 2'b11, "R13 read-array ignored while busy");
    repeat (40) @(negedge clk);
    expect_item(K_RB, 16'h0000, "R8 deselected job continues");
    sample_now();
    stall = 1'b0;
    repeat (30) @(negedge clk);
    expect_item(K_RB, 16'h0001, "R8 ready after done");
    sample_now();
    read_chk(12'd301, 1'b0, 16'h0080, 2'b11, "R13 still status view");

    // R7/R5/R6: abort by power-down
    stall = 1'b1;
    bus_write(12'h000, 16'h0040, 1'b0);
    bus_write(12'd600, 16'h0F0F, 1'b0);
    @(negedge clk);
    addr = 12'd600; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; rp_n = 1'b0;
    repeat (8) @(negedge clk);
    expect_item(K_OE, 16'h0000, "R5 no drive in power-down");
    expect_item(K_RB, 16'h0001, "R7 ready after abort");
    expect_item(K_BAD, 16'h0008, "R7 block 3 flagged");
    expect_item(K_ABORTS, 16'd1, "R7 single abort pulse");
    sample_now();
    rp_n = 1'b1;
    repeat (10) @(negedge clk);
    expect_item(K_DQ, init_val(600), "R2 array after power-down exit");
    expect_item(K_OE, 16'h0003, "R5 word read drives both lanes");
    sample_now();
    ce_n = 1'b1; oe_n = 1'b1;
    stall = 1'b0;
    bus_write(12'h000, 16'h0070, 1'b0);
    read_chk(12'd0, 1'b0, 16'h0080, 2'b11, "R6 status 80h after power-down");

    // R6: writes ignored in power-down
    @(negedge clk); rp_n = 1'b0;
    bus_write(12'h000, 16'h0090, 1'b0);
    rp_n = 1'b1;
    repeat (6) @(negedge clk);
    read_chk(12'd1, 1'b0, init_val(1), 2'b11, "R6 write ignored in power-down");

    // R11/R12: bad confirm and sticky error bits
    bus_write(12'h000, 16'h0020, 1'b0);
    bus_write(12'd700, 16'h0055, 1'b0);
    read_chk(12'd0, 1'b0, 16'h00B0, 2'b11, "R11 bad confirm sets bits 5 and 4");
    bus_write(12'h000, 16'h00FF, 1'b0);
    bus_write(12'h000, 16'h0070, 1'b0);
    read_chk(12'd0, 1'b0, 16'h00B0, 2'b11, "R12 error bits sticky");
    bus_write(12'h000, 16'h0050, 1'b0);
    read_chk(12'd0, 1'b0, 16'h0080, 2'b11, "R12 clear status");

    // R11: good erase clears the bad flag
    bus_write(12'h000, 16'h0020, 1'b0);
    bus_write(12'd700, 16'h00D0, 1'b0);
    wait_ready();
    expect_item(K_BAD, 16'h0000, "R11 erase clears flag");
    expect_item(K_OP, 16'd1, "R11 erase op");
    expect_item(K_BLK, 16'd3, "R11 erase block");
    sample_now();

    // R10: block map boundaries
    begin
      logic [AW-1:0] pts [11] = '{12'd255, 12'd256, 12'd383, 12'd384, 12'd511, 12'd512,
                                  12'd1023, 12'd1024, 12'd2047, 12'd2048, 12'd4095};
      int blks [11] = '{0, 1, 1, 2, 2, 3, 3, 4, 4, 5, 6};
      for (int i = 0; i < 11; i++) begin
        bus_write(12'h000, 16'h0020, 1'b0);
        bus_write(pts[i], 16'h00D0, 1'b0);
        wait_ready();
        expect_item(K_BLK, 16'(blks[i]), $sformatf("R10 map addr %0d", pts[i]));
        sample_now();
      end
    end

    // R9: byte mode
    @(negedge clk); byte_n = 1'b0;
    bus_write(12'h000, 16'h00FF, 1'b0);
    read_chk(12'd300, 1'b0, 16'h0034, 2'b01, "R9 low byte");
    read_chk(12'd300, 1'b1, 16'h0012, 2'b01, "R9 high byte");
    bus_write(12'h000, 16'h0040, 1'b0);
    bus_write(12'd10, 16'h80AB, 1'b0);
    wait_ready();
    expect_item(K_WDATA, 16'hABFF, "R9 byte program fill");
    sample_now();
    bus_write(12'h000, 16'h00FF, 1'b0);
    read_chk(12'd10, 1'b1, 16'h00AB, 2'b01, "R9 programmed high byte");
    read_chk(12'd10, 1'b0, 16'h00FF, 2'b01, "R9 filled low byte");
    @(negedge clk); byte_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk(12'd10, 1'b0, 16'hABFF, 2'b11, "R9 word view after byte program");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule